// File: doc/BRIEF.md
# Predicated Interleaved Pairwise Adder

This unit is a vector datapath stage. It takes two source vectors, a per-byte predicate and a two-bit element-size code. Within each source it adds neighbouring element pairs. The pair sums are then interleaved by lane. An even result lane receives the sum of a pair taken from the first source. An odd result lane receives the sum of the matching pair from the second source. Lanes switched off by the predicate pass the first source's element through unchanged. The output vector is meant to overwrite the first source operand in the register file that surrounds the unit.

An operation enters through a valid/ready handshake. The operands, predicate and size code are captured together on the accepting edge. The single result register presents the vector exactly one cycle later. The result stays on the output until the consumer takes it. The adders are fixed combinational logic, so the timing never depends on operand values.

Top module: `vpair_add`

## Requirements
- R1: `in_size` selects the element width as 8 << code (0: 8, 1: 16, 2: 32, 3: 64 bits). Lane e occupies bits [e*width +: width] of every vector, and there are VLEN/width lanes.
- R2: An active even lane e produces source-one lane e plus source-one lane e+1.
- R3: An active odd lane e produces source-two lane e-1 plus source-two lane e.
- R4: An inactive lane produces source-one lane e unchanged.
- R5: A lane is active when predicate bit e*width/8 is 1, which is the bit of the lane's lowest byte. The other predicate bits inside that lane have no effect.
- R6: Sums are unsigned. Any carry out of the lane width is dropped, so the sum wraps modulo 2^width.
- R7: An input accepted on one edge (`in_valid` and `in_ready` both high) gives `out_valid` high with its result after that edge. This latency is the same for any operand data. `out_valid` is never raised without an accepted input.
- R8: `in_ready` is high whenever `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, both `out_valid` and `out_result` hold.
- R9: While `rst_n` is low, `out_valid` is low.
- R10: Operands, predicate and size code are sampled only on the accepting edge. Input changes on cycles when nothing is accepted do not alter a held result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept an operation |
| in_src1 | input | VLEN | First source vector |
| in_src2 | input | VLEN | Second source vector |
| in_pred | input | VLEN/8 | Governing predicate, one bit per byte |
| in_size | input | 2 | Element size code |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | VLEN | Result vector that replaces source one |

## Verification
The bench builds the unit with the default vector length of 256 bits. That length gives 32, 16, 8 and 4 lanes for the four sizes and a 32-bit predicate. Every size therefore has several even/odd lane pairs, and each size skips a different set of predicate bits. All-ones operands force the wrap of R6 at every width. A stalled consumer, with new inputs offered at the same time, exercises the hold and sampling rules.

// File: rtl/vpa_pkg.sv
package vpa_pkg;

  typedef enum logic [1:0] {
    EW_BYTE = 2'b00,
    EW_HALF = 2'b01,
    EW_WORD = 2'b10,
    EW_DBL  = 2'b11
  } ew_code_e;

  localparam int unsigned NUM_SIZES = 4;
  localparam int unsigned MAX_EW    = 64;

  // element width in bits for a size code
  function automatic int unsigned ew_bits(input int unsigned code);
    return 8 << code;
  endfunction

  // unsigned lane add, wrapped to w bits (carry out discarded)
  function automatic logic [MAX_EW-1:0] lane_add(input logic [MAX_EW-1:0] a,
                                                 input logic [MAX_EW-1:0] b,
                                                 input int unsigned w);
    logic [MAX_EW:0]   full;
    logic [MAX_EW-1:0] mask;
    full = {1'b0, a} + {1'b0, b};
    mask = (w >= MAX_EW) ? '1 : ((64'd1 << w) - 64'd1);
    return full[MAX_EW-1:0] & mask;
  endfunction

endpackage

// File: rtl/vpa_size_path.sv
module vpa_size_path #(
  parameter int unsigned VLEN      = 256,
  parameter int unsigned SIZE_CODE = 0
) (
  input  logic [VLEN-1:0]   src1,
  input  logic [VLEN-1:0]   src2,
  input  logic [VLEN/8-1:0] pred,
  output logic [VLEN-1:0]   res,
  output logic [VLEN/8-1:0] lane_act
);
  import vpa_pkg::*;

  localparam int unsigned EW    = 8 << SIZE_CODE;
  localparam int unsigned LANES = VLEN / EW;
  localparam int unsigned BPL   = EW / 8;
  localparam int unsigned PAIRS = LANES / 2;

  generate
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
      localparam int unsigned LE = 2 * p;
      localparam int unsigned LO = 2 * p + 1;
      logic [EW-1:0]     a_lo, a_hi, b_lo, b_hi;
      logic [MAX_EW-1:0] sum_even, sum_odd;
      logic              act_even, act_odd;

      assign a_lo     = src1[LE*EW +: EW];
      assign a_hi     = src1[LO*EW +: EW];
      assign b_lo     = src2[LE*EW +: EW];
      assign b_hi     = src2[LO*EW +: EW];
      assign act_even = pred[LE*BPL];
      assign act_odd  = pred[LO*BPL];
      assign sum_even = lane_add(MAX_EW'(a_lo), MAX_EW'(a_hi), EW);
      assign sum_odd  = lane_add(MAX_EW'(b_lo), MAX_EW'(b_hi), EW);

      assign res[LE*EW +: EW] = act_even ? sum_even[EW-1:0] : a_lo;
      assign res[LO*EW +: EW] = act_odd  ? sum_odd[EW-1:0]  : a_hi;
      assign lane_act[LE] = act_even;
      assign lane_act[LO] = act_odd;
    end
    if (LANES < VLEN / 8) begin : g_act_pad
      assign lane_act[VLEN/8-1:LANES] = '0;
    end
  endgenerate

endmodule

// File: rtl/vpa_result_sel.sv
module vpa_result_sel #(
  parameter int unsigned VLEN = 256
) (
  input  logic [VLEN-1:0]   src1,
  input  logic [VLEN-1:0]   src2,
  input  logic [VLEN/8-1:0] pred,
  input  logic [1:0]        size,
  output logic [VLEN-1:0]   res,
  output logic [VLEN/8-1:0] lane_act
);
  import vpa_pkg::*;

  logic [VLEN-1:0]   res_by_size [NUM_SIZES];
  logic [VLEN/8-1:0] act_by_size [NUM_SIZES];

  generate
    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
      vpa_size_path #(.VLEN(VLEN), .SIZE_CODE(s)) path_i (
        .src1     (src1),
        .src2     (src2),
        .pred     (pred),
        .res      (res_by_size[s]),
        .lane_act (act_by_size[s])
      );
    end
  endgenerate

  always_comb begin
    res      = res_by_size[size];
    lane_act = act_by_size[size];
  end

endmodule

// File: rtl/vpa_out_stage.sv
module vpa_out_stage #(
  parameter int unsigned W = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  logic         held;
  logic [W-1:0] data_q;

  assign up_ready = !held || dn_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held   <= 1'b0;
      data_q <= '0;
    end else if (up_ready) begin
      held <= up_valid;
      if (up_valid) data_q <= up_data;
    end
  end

  assign dn_valid = held;
  assign dn_data  = data_q;

endmodule

// File: rtl/vpair_add.sv
module vpair_add #(
  parameter int unsigned VLEN = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [VLEN-1:0]   in_src1,
  input  logic [VLEN-1:0]   in_src2,
  input  logic [VLEN/8-1:0] in_pred,
  input  logic [1:0]        in_size,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [VLEN-1:0]   out_result
);
  localparam int unsigned PW = VLEN / 8;

  logic [VLEN-1:0] comb_res;
  logic [PW-1:0]   lane_act;
  logic            in_fire;
  logic            out_fire;

  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;

  vpa_result_sel #(.VLEN(VLEN)) sel_i (
    .src1     (in_src1),
    .src2     (in_src2),
    .pred     (in_pred),
    .size     (in_size),
    .res      (comb_res),
    .lane_act (lane_act)
  );

  vpa_out_stage #(.W(VLEN)) stage_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (comb_res),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (out_result)
  );

endmodule

// File: rtl/vpair_add_chk.sv
module vpair_add_chk #(
  parameter int unsigned VLEN = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [VLEN-1:0]   in_src1,
  input logic [VLEN/8-1:0] in_pred,
  input logic              out_valid,
  input logic              out_ready,
  input logic [VLEN-1:0]   out_result,
  input logic              in_fire,
  input logic              out_fire
);

  p_reset_idle_r9: assert property (@(posedge clk) !rst_n |-> !out_valid);

  p_accept_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> out_valid);

  p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_fire && (!out_valid || out_fire)) |=> !out_valid);

  p_ready_when_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));

  p_stall_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_fire);

  p_all_inactive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && in_pred == '0) |=> out_result == $past(in_src1));

endmodule

bind vpair_add vpair_add_chk #(.VLEN(VLEN)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_src1    (in_src1),
  .in_pred    (in_pred),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .in_fire    (in_fire),
  .out_fire   (out_fire)
);

// File: tb/vpair_add_tb_top.sv
module vpair_add_tb_top;
  localparam int unsigned VL = 256;
  localparam int unsigned PW = VL / 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [VL-1:0] in_src1 = '0;
  logic [VL-1:0] in_src2 = '0;
  logic [PW-1:0] in_pred = '0;
  logic [1:0]    in_size = 2'd0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [VL-1:0] out_result;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  vpair_add #(.VLEN(VL)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_src1(in_src1), .in_src2(in_src2), .in_pred(in_pred), .in_size(in_size),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result)
  );

  // reference: walk lane pairs, pick each lane's element by shifting
  function automatic logic [63:0] get_el(input logic [VL-1:0] v, input int idx, input int w);
    logic [VL-1:0] sh;
    logic [63:0]   m;
    sh = v >> (idx * w);
    m  = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
    return sh[63:0] & m;
  endfunction

  function automatic logic [VL-1:0] ref_op(input logic [VL-1:0] s1, input logic [VL-1:0] s2,
                                          input logic [PW-1:0] p, input logic [1:0] sz);
    logic [VL-1:0] acc;
    logic [63:0]   m, ev, od;
    int            w;
    w   = 8 * (1 << sz);
    m   = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
    acc = '0;
    for (int i = 0; i < int'(VL) / w; i += 2) begin
      ev = p[i * w / 8]       ? ((get_el(s1, i, w) + get_el(s1, i + 1, w)) & m) : get_el(s1, i, w);
      od = p[(i + 1) * w / 8] ? ((get_el(s2, i, w) + get_el(s2, i + 1, w)) & m) : get_el(s1, i + 1, w);
      acc |= VL'(ev) << (i * w);
      acc |= VL'(od) << ((i + 1) * w);
    end
    return acc;
  endfunction

  function automatic logic [VL-1:0] rand_vec();
    logic [VL-1:0] v;
    for (int k = 0; k < int'(VL) / 32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic chk_vec(input string tag, input logic [VL-1:0] act, input logic [VL-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [VL-1:0] s1, input logic [VL-1:0] s2,
                       input logic [PW-1:0] p, input logic [1:0] sz, input string tag);
    @(negedge clk);
    out_ready = 1'b1;
    in_valid  = 1'b1;
    in_src1 = s1; in_src2 = s2; in_pred = p; in_size = sz;
    @(negedge clk);
    in_valid = 1'b0;
    chk_bit({tag, " R7 valid"}, out_valid, 1'b1);
    chk_vec(tag, out_result, ref_op(s1, s2, p, sz));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [VL-1:0] a, b, ra;
    logic [PW-1:0] p;
    void'($urandom(32'd1234));

    // R9 reset state
    repeat (3) @(negedge clk);
    chk_bit("R9 out_valid in reset", out_valid, 1'b0);
    chk_bit("R8 ready while empty", in_ready, 1'b1);
    rst_n = 1'b1;

    // directed: all lanes active, small values, each size (R1 R2 R3)
    a = '0; b = '0;
    for (int k = 0; k < int'(VL) / 8; k++) begin
      a[k*8 +: 8] = 8'(k + 1);
      b[k*8 +: 8] = 8'(2 * k + 3);
    end
    for (int s = 0; s < 4; s++) do_op(a, b, '1, 2'(s), "R1 R2 R3 full predicate");

    // R6 all-ones operands wrap at every width
    for (int s = 0; s < 4; s++) begin
      do_op('1, '1, '1, 2'(s), "R6 carry dropped");
      chk_vec("R6 lane0 is all-ones minus one", out_result & VL'((64'd1 << (8 << s)) - 64'd1 | (s == 3 ? 64'hFFFF_FFFF_FFFF_FFFF : 64'd0)),
              (s == 3) ? VL'(64'hFFFF_FFFF_FFFF_FFFE) : VL'(((64'd1 << (8 << s)) - 64'd2)));
    end

    // R4 predicate all zero: result equals source one
    a = rand_vec(); b = rand_vec();
    do_op(a, b, '0, 2'd2, "R4 all inactive");
    chk_vec("R4 passthrough", out_result, a);

    // R5 only non-lowest bytes of 64-bit lanes set: all inactive
    do_op(a, b, ~32'h0101_0101, 2'd3, "R5 upper bytes ignored");
    chk_vec("R5 passthrough", out_result, a);
    // R5 half-word lanes with odd byte bits only
    do_op(a, b, 32'hAAAA_AAAA, 2'd1, "R5 odd byte bits ignored");
    chk_vec("R5 odd bytes passthrough", out_result, a);
    do_op(a, b, 32'h5555_5555, 2'd1, "R5 even byte bits active");

    // R10 / R8 stall: hold result while new inputs are offered
    ra = ref_op(a, b, 32'h0F0F_3C3C, 2'd0);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_src1 = a; in_src2 = b; in_pred = 32'h0F0F_3C3C; in_size = 2'd0;
    @(negedge clk);
    chk_bit("R8 not ready when stalled", in_ready, 1'b0);
    in_src1 = b; in_src2 = a; in_pred = 32'hFFFF_0000; in_size = 2'd2;
    chk_vec("R10 first result", out_result, ra);
    @(negedge clk);
    chk_vec("R10 held under stall", out_result, ra);
    chk_bit("R8 valid held", out_valid, 1'b1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk_vec("R10 second op after release", out_result, ref_op(b, a, 32'hFFFF_0000, 2'd2));
    @(negedge clk);
    chk_bit("R7 no spurious valid", out_valid, 1'b0);

    // random stimulus across all sizes
    for (int n = 0; n < 400; n++) begin
      p = $urandom;
      do_op(rand_vec(), rand_vec(), p, 2'(n % 4), "R2 R3 R4 R5 random");
    end

    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule